// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Coprocessor

This block is a small register-mapped arithmetic unit. It adds or subtracts two unsigned numbers of eight packed decimal digits, each held in a 32-bit register. Software loads the first operand, then the second operand, and then writes a command word. The operation runs on that command write, and the result is readable in the next cycle.

The unit keeps the carry from its last operation. A later command can take that carry as its carry-in, which lets software build 16-, 24- or wider-digit sums and differences one 8-digit slice at a time. For a wide sum, the lowest slice runs with no carry-in and each higher slice chains the carry. For a wide difference, the lowest slice forces a carry-in of one and each higher slice chains the carry.

The bus side is a simple synchronous register port. It accepts byte, word and longword accesses and uses big-endian byte lanes. Only address bits 6:0 are decoded, so the register set repeats every 128 bytes.

Top module: `bcd_calc_unit`

## Requirements
- R1: With command bit 0 = 1, the result is (A + B + cin) mod 10^8. A and B are the two operands. Every value is 8 packed BCD digits with the least significant digit in bits 3:0.
- R2: With command bit 0 = 0, the result is (A + (99999999 − B) + cin) mod 10^8, which is the nines' complement of B added to A. A carry-out of 1 means no borrow occurred.
- R3: The carry-in is 1 when command bit 2 is set. When bit 2 is clear and bit 1 is set, the carry-in is the stored carry from the previous operation. When neither bit is set, the carry-in is 0.
- R4: The stored carry is 1 exactly when the unreduced sum in R1 or R2 is 10^8 or more. A 16-bit read at offset 0x10 returns this carry in bit 12 and the last command bits 2:0 in bits 2:0. All other bits read as 0.
- R5: A command write updates the result and the carry at that clock edge, so a read in the next cycle returns the new values. Without a command write, the result and the carry hold their values.
- R6: The register offsets are 0x10 (command/status, 16-bit), 0x14 (operand A), 0x18 (operand B) and 0x1C (result). Every other offset in the 128-byte window reads 0 and ignores writes.
- R7: Address bits 7 and above are ignored, so offset X+128·k reaches the same register as offset X.
- R8: bus_size selects the access width: 0 = byte, 1 = word, 2 or 3 = longword.
  - The registers use big-endian lanes: the byte at offset o within a 4-byte slot is bits [31−8o : 24−8o].
  - A word access uses address bit 1 to pick the halfword.
  - Write data and read data are right-justified on the bus.
  - The 16-bit command register fills bytes 0x10 and 0x11, so its bits 7:0 sit at byte 0x11. Bytes 0x12 and 0x13 read 0.
- R9: A command is launched by any write that covers byte 0x11. A write that covers only byte 0x10 changes nothing.
- R10: The result register and the carry status are read-only. A write to 0x1C leaves them unchanged.
- R11: After reset, all registers and the carry read 0.
- R12: bus_ready is always 1, so every cycle with bus_valid high carries one transfer and there is no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_ready | output | 1 | Always 1, meaning the request is accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address; only bits 6:0 are decoded |
| bus_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Right-justified read data for the current address (combinational) |

## Verification
The bench builds the unit with its default ADDR_W of 16 and 8 digits per slice. The 16-bit address makes the aliases at 0x0080 and 0xFF80 reachable, and the bench checks both. With 8 digits per slice, the bench can chain three slices into 24-digit add and subtract and compare them against an integer model. The random phase mixes all eight command codes over valid BCD operands. This exercises chained, forced and cleared carries after both carry states.

// File: rtl/bcd_calc_pkg.sv
package bcd_calc_pkg;
  localparam int BUS_W    = 32;
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int DIGITS   = BUS_W / 4;

  // slot index = address bits 6:2
  localparam logic [4:0] SLOT_CMD = 5'd4;
  localparam logic [4:0] SLOT_OPA = 5'd5;
  localparam logic [4:0] SLOT_OPB = 5'd6;
  localparam logic [4:0] SLOT_RES = 5'd7;

  localparam int CMD_ADD_BIT   = 0;
  localparam int CMD_CHAIN_BIT = 1;
  localparam int CMD_FORCE_BIT = 2;
  localparam int STAT_CARRY_BIT = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] s,
  output logic       cout
);
  logic [5:0] raw;
  logic [5:0] adj;

  always_comb begin
    raw = {2'b00, a} + {2'b00, b} + {5'b0, cin};
    adj = raw + 6'd6;
    if (raw > 6'd9) begin
      s    = adj[3:0];
      cout = 1'b1;
    end else begin
      s    = raw[3:0];
      cout = 1'b0;
    end
  end

  // valid decimal inputs must yield a valid decimal digit (R1)
  always_comb begin
    if (a <= 4'd9 && b <= 4'd9) begin
      p_digit_range_r1: assert (s <= 4'd9);
    end
  end
endmodule

// File: rtl/bcd_slice_adder.sv
module bcd_slice_adder #(
  parameter int DIGITS = 8,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] carry;
  assign carry[0] = cin;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] b_eff;
    assign b_eff = sub ? (4'd9 - opb[4*d +: 4]) : opb[4*d +: 4];
    bcd_digit_add u_dig (
      .a   (opa[4*d +: 4]),
      .b   (b_eff),
      .cin (carry[d]),
      .s   (sum[4*d +: 4]),
      .cout(carry[d+1])
    );
  end

  assign cout = carry[DIGITS];

  // equal operands subtracted with carry-in 1 give zero, no borrow (R2)
  always_comb begin
    if (sub && cin && opa == opb) begin
      p_equal_sub_r2: assert (sum == '0 && cout);
    end
  end
endmodule

// File: rtl/bcd_bus_lanes.sv
module bcd_bus_lanes
  import bcd_calc_pkg::*;
(
  input  acc_size_e          size,
  input  logic [1:0]         ofs,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [BUS_W-1:0]   slot_rd,
  output logic [BUS_BYTES-1:0] lane_en,
  output logic [BUS_W-1:0]   wr_aligned,
  output logic [BUS_W-1:0]   rd_just
);
  logic [1:0] byte_pos;
  assign byte_pos = ~ofs;  // lane o sits at bits [8*(3-o) +: 8]

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_en    = 4'b0001 << ofs;
        wr_aligned = {4{wdata[7:0]}};
        rd_just    = {24'b0, slot_rd[{byte_pos, 3'b000} +: 8]};
      end
      SZ_WORD: begin
        lane_en    = ofs[1] ? 4'b1100 : 4'b0011;
        wr_aligned = {2{wdata[15:0]}};
        rd_just    = {16'b0, (ofs[1] ? slot_rd[15:0] : slot_rd[31:16])};
      end
      default: begin
        lane_en    = 4'b1111;
        wr_aligned = wdata;
        rd_just    = slot_rd;
      end
    endcase
  end
endmodule

// File: rtl/bcd_calc_unit.sv
module bcd_calc_unit
  import bcd_calc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [BUS_W-1:0] opa_q, opb_q, res_q;
  logic             carry_q;
  logic [2:0]       cmd_q;

  logic [4:0]           slot;
  logic [1:0]           ofs;
  logic [BUS_BYTES-1:0] lane_en;
  logic [BUS_W-1:0]     wr_aligned, slot_rd;
  logic                 wr_en, cmd_fire, cin;
  logic [2:0]           new_cmd;
  logic [BUS_W-1:0]     sum;
  logic                 cout;
  logic                 unused_addr_hi;

  assign bus_ready      = 1'b1;
  assign slot           = bus_addr[6:2];
  assign ofs            = bus_addr[1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:7];
  assign wr_en          = bus_valid && bus_write;

  always_comb begin
    case (slot)
      SLOT_CMD: slot_rd = {3'b000, carry_q, 9'b0, cmd_q, 16'h0000};
      SLOT_OPA: slot_rd = opa_q;
      SLOT_OPB: slot_rd = opb_q;
      SLOT_RES: slot_rd = res_q;
      default:  slot_rd = '0;
    endcase
  end

  bcd_bus_lanes u_lanes (
    .size      (acc_size_e'(bus_size)),
    .ofs       (ofs),
    .wdata     (bus_wdata),
    .slot_rd   (slot_rd),
    .lane_en   (lane_en),
    .wr_aligned(wr_aligned),
    .rd_just   (bus_rdata)
  );

  // command bits 7:0 live in lane 1 (slot bits 23:16)
  assign new_cmd  = wr_aligned[16 +: 3];
  assign cmd_fire = wr_en && (slot == SLOT_CMD) && lane_en[1];

  always_comb begin
    if (new_cmd[CMD_FORCE_BIT])      cin = 1'b1;
    else if (new_cmd[CMD_CHAIN_BIT]) cin = carry_q;
    else                             cin = 1'b0;
  end

  bcd_slice_adder #(.DIGITS(DIGITS)) u_add (
    .opa (opa_q),
    .opb (opb_q),
    .sub (~new_cmd[CMD_ADD_BIT]),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  function automatic logic [BUS_W-1:0] merge_lanes(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] new_v,
    input logic [BUS_BYTES-1:0] en
  );
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (en[i]) r[8*(BUS_BYTES-1-i) +: 8] = new_v[8*(BUS_BYTES-1-i) +: 8];
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
      carry_q <= 1'b0;
      cmd_q   <= '0;
    end else if (wr_en) begin
      case (slot)
        SLOT_OPA: opa_q <= merge_lanes(opa_q, wr_aligned, lane_en);
        SLOT_OPB: opb_q <= merge_lanes(opb_q, wr_aligned, lane_en);
        SLOT_CMD: if (lane_en[1]) begin
          cmd_q   <= new_cmd;
          res_q   <= sum;
          carry_q <= cout;
        end
        default: ;
      endcase
    end
  end

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |=> $stable(res_q) && $stable(carry_q));

  p_result_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> res_q == $past(sum) && carry_q == $past(cout));

  p_opa_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && slot == SLOT_OPA) |=> $stable(opa_q));

  p_force_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && new_cmd[CMD_FORCE_BIT] && !new_cmd[CMD_ADD_BIT] && opa_q == opb_q
    |=> res_q == '0 && carry_q);
endmodule

// File: tb/bcd_calc_unit_test.sv
module bcd_calc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #2 clk = ~clk;

  bcd_calc_unit #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  logic [31:0] m_a = '0, m_b = '0, m_res = '0;
  logic        m_carry = 1'b0;
  logic [2:0]  m_cmd = '0;

  function automatic longint bcd2int(input logic [31:0] v);
    longint r = 0;
    for (int i = 7; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [31:0] int2bcd(input longint n);
    logic [31:0] r = '0;
    longint x = n;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [31:0] slot_of(input logic [15:0] addr);
    case (addr[6:0] & 7'h7C)
      7'h10:   return {3'b0, m_carry, 9'b0, m_cmd, 16'h0};
      7'h14:   return m_a;
      7'h18:   return m_b;
      7'h1C:   return m_res;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expect_read(input logic [15:0] addr, input logic [1:0] sz);
    logic [31:0] s = slot_of(addr);
    int o = int'(addr[1:0]);
    if (sz == 2'd0) return {24'h0, s[31-8*o -: 8]};
    if (sz == 2'd1) return {16'h0, (addr[1] ? s[15:0] : s[31:16])};
    return s;
  endfunction

  task automatic model_write(input logic [15:0] addr, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] img = '0;
    logic [3:0]  en = '0;
    int o = int'(addr[1:0]);
    longint a, b, r;
    logic cin;
    if (sz == 2'd0) begin en[o] = 1'b1; img[31-8*o -: 8] = d[7:0]; end
    else if (sz == 2'd1) begin
      if (addr[1]) begin en = 4'b1100; img[15:0] = d[15:0]; end
      else begin en = 4'b0011; img[31:16] = d[15:0]; end
    end else begin en = 4'b1111; img = d; end
    case (addr[6:0] & 7'h7C)
      7'h14: for (int i = 0; i < 4; i++) if (en[i]) m_a[31-8*i -: 8] = img[31-8*i -: 8];
      7'h18: for (int i = 0; i < 4; i++) if (en[i]) m_b[31-8*i -: 8] = img[31-8*i -: 8];
      7'h10: if (en[1]) begin
        m_cmd = img[18:16];
        cin = m_cmd[2] ? 1'b1 : (m_cmd[1] ? m_carry : 1'b0);
        a = bcd2int(m_a);
        b = bcd2int(m_b);
        r = m_cmd[0] ? (a + b + cin) : (a + (99999999 - b) + cin);
        m_carry = (r >= 100000000);
        m_res = int2bcd(r % 100000000);
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] addr, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    model_write(addr, sz, d);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [15:0] addr, input logic [1:0] sz);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr; bus_size = sz;
    #1;
    check(tag, bus_rdata, expect_read(addr, sz));
    check({tag, " R12 ready"}, {31'b0, bus_ready}, 32'h1);
  endtask

  task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    wr(16'h0014, 2'd2, a);
    wr(16'h0018, 2'd2, b);
    wr(16'h0010, 2'd1, {29'b0, c});
    rd({tag, " R5 result"}, 16'h001C, 2'd2);
    rd({tag, " R4 status"}, 16'h0010, 2'd1);
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lo1, lo2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset values
    rd("R11 cmd", 16'h0010, 2'd2);
    rd("R11 opa", 16'h0014, 2'd2);
    rd("R11 opb", 16'h0018, 2'd2);
    rd("R11 res", 16'h001C, 2'd2);

    // R1 addition, R4 carry out
    op("R1 add", 32'h12345678, 32'h87654321, 3'b001);
    check("R1 literal", m_res, 32'h99999999);
    op("R1 add wrap", 32'h99999999, 32'h00000001, 3'b001);
    check("R4 literal carry", {31'b0, m_carry}, 32'h1);
    check("R1 literal zero", m_res, 32'h0);

    // R2 subtraction with borrow and without
    op("R2 sub borrow", 32'h00000001, 32'h00000002, 3'b100);
    check("R2 literal", m_res, 32'h99999999);
    op("R2 sub ok", 32'h00005000, 32'h00001234, 3'b100);
    check("R2 literal ok", m_res, 32'h00003766);

    // R3 carry-in selection
    op("R3 set carry", 32'h99999999, 32'h00000001, 3'b001);
    op("R3 chain", 32'h00000010, 32'h00000020, 3'b011);
    op("R3 none", 32'h00000010, 32'h00000020, 3'b001);
    op("R3 both", 32'h00000010, 32'h00000020, 3'b111);
    op("R3 force eq", 32'h00424242, 32'h00424242, 3'b100);

    // 24-digit chained add: 999..9 (24) + 1
    op("R3 chain24 add lo", 32'h99999999, 32'h00000001, 3'b001);
    op("R3 chain24 add mid", 32'h99999999, 32'h00000000, 3'b011);
    op("R3 chain24 add hi", 32'h99999999, 32'h00000000, 3'b011);
    check("R3 chain24 add final", {m_res[31:1], m_carry}, 32'h1);

    // 24-digit chained sub: 1_00000000_00000000 - 1
    op("R2 chain24 sub lo", 32'h00000000, 32'h00000001, 3'b100);
    op("R2 chain24 sub mid", 32'h00000000, 32'h00000000, 3'b010);
    op("R2 chain24 sub hi", 32'h00000001, 32'h00000000, 3'b010);
    check("R2 chain24 sub hi lit", m_res, 32'h0);

    // R8 lanes: byte writes build operand A, word write operand B
    wr(16'h0014, 2'd0, 32'h12);
    wr(16'h0015, 2'd0, 32'h34);
    wr(16'h0016, 2'd0, 32'h56);
    wr(16'h0017, 2'd0, 32'h78);
    rd("R8 byte build", 16'h0014, 2'd2);
    check("R8 byte literal", m_a, 32'h12345678);
    wr(16'h001A, 2'd1, 32'h0011);
    wr(16'h0018, 2'd1, 32'h0002);
    rd("R8 word build", 16'h0018, 2'd2);
    rd("R8 byte read", 16'h0016, 2'd0);
    rd("R8 word read", 16'h001E, 2'd1);
    rd("R8 pad read", 16'h0012, 2'd1);

    // R9 byte 0x11 launches, byte 0x10 does not
    wr(16'h0011, 2'd0, 32'h01);
    rd("R9 byte launch", 16'h001C, 2'd2);
    wr(16'h0014, 2'd2, 32'h00000005);
    wr(16'h0010, 2'd0, 32'hFF);
    rd("R9 hi byte no launch", 16'h001C, 2'd2);
    rd("R9 status", 16'h0010, 2'd1);
    wr(16'h0010, 2'd2, 32'h00010000);
    rd("R9 long launch", 16'h001C, 2'd2);

    // R10 result read-only
    wr(16'h001C, 2'd2, 32'h55555555);
    rd("R10 res ro", 16'h001C, 2'd2);
    wr(16'h0010, 2'd0, 32'h10);
    rd("R10 carry ro", 16'h0010, 2'd1);

    // R6 unmapped offsets
    wr(16'h0004, 2'd2, 32'hDEADBEEF);
    rd("R6 unmapped", 16'h0004, 2'd2);
    rd("R6 opa kept", 16'h0014, 2'd2);

    // R7 aliasing
    wr(16'h0094, 2'd2, 32'h00000321);
    rd("R7 alias 0x80", 16'h0014, 2'd2);
    wr(16'hFF98, 2'd2, 32'h00000123);
    rd("R7 alias 0xFF80", 16'h0098, 2'd2);
    wr(16'h7F90, 2'd1, 32'h0001);
    rd("R7 alias launch", 16'hAB9C, 2'd2);

    // R1/R2/R3 random sweep
    for (int k = 0; k < 300; k++) begin
      lo1 = int2bcd(longint'($urandom % 100000000));
      lo2 = int2bcd(longint'($urandom % 100000000));
      if (k % 7 == 0) lo2 = lo1;
      op("R1 R2 R3 random", lo1, lo2, 3'($urandom % 8));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule